// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This block owns the fetch address of a 32-bit core whose jumps and calls take effect after exactly one delay-slot instruction. Each cycle that `issue_i` is high, one instruction at the current address `pc_o` completes decode. The decoder gives the block a branch kind, a branch offset, two compare operands, and the value and index of the register named as an indirect source. The block then updates `pc_o` to the next fetch address.

Jumps and calls move the address to the sequential instruction first, which is the delay slot, and raise `slot_o`. They reach their target only when the following instruction issues. A call also produces a one-cycle link write of the address just past the slot. The compare branches redirect at once, with no slot. Indirect targets are frozen when the branch issues. Any branch found in a delay slot is dropped and reported.

All outputs are registered and change only on the clock edge after an issue.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after reset, `pc_o` becomes 0, `slot_o` is 0, and no delay-slot target is pending.
- R2: `kind_i` codes are 0 none, 1 jump, 2 jump-register, 3 branch-if-equal, 4 branch-if-not-equal, 5 call, 6 call-register. An issued non-branch advances `pc_o` by 4. With `issue_i` low, `pc_o`, `slot_o` and any pending target hold, and no pulse is raised.
- R3: An issued jump or call (codes 1, 5) sets `pc_o` to `pc_o+4`. After the next issued instruction, `pc_o` becomes (old `pc_o`+4) + (sign-extended 26-bit `off_i` << 2).
- R4: An issued jump-register or call-register (codes 2, 6) sets `pc_o` to `pc_o+4`. After the next issued instruction, `pc_o` becomes the value `src_val_i` had when the branch issued. A later change to `src_val_i` has no effect on it.
- R5: An indirect target with its low two bits nonzero is used unchanged and raises no error output.
- R6: Branch-if-equal redirects to `pc_o+4` + (sign-extended low 16 bits of `off_i` << 2) only when `opa_i == opb_i`. Branch-if-not-equal does so only when they differ. Otherwise `pc_o` advances by 4. Neither sets `slot_o`.
- R7: An issued call or call-register pulses `link_we_o` for one cycle, with `link_o` = issuing address + 8.
- R8: A call-register whose `src_idx_i` is 1 pulses `err_link_src_o` for one cycle. The call still proceeds.
- R9: A branch of any kind issued while `slot_o` is high is ignored. `pc_o` goes to the pending target, no link is written, and `err_slot_o` pulses for one cycle.
- R10: `slot_o` is high exactly while the instruction at `pc_o` is the delay slot of a jump or call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One instruction at `pc_o` completes decode this cycle |
| kind_i | input | 3 | Branch kind code |
| off_i | input | 26 | Branch offset in words; the short form uses bits 15:0 |
| opa_i | input | 32 | First compare operand |
| opb_i | input | 32 | Second compare operand |
| src_val_i | input | 32 | Value of the indirect source register |
| src_idx_i | input | 5 | Index of the indirect source register |
| pc_o | output | 32 | Address of the instruction to fetch and issue next |
| slot_o | output | 1 | Instruction at `pc_o` is a delay slot |
| link_we_o | output | 1 | Link register write strobe |
| link_o | output | 32 | Link value to write |
| err_slot_o | output | 1 | A branch was issued inside a delay slot |
| err_link_src_o | output | 1 | Call-register named the link register as its source |

## Verification
The hardest situations to reach are the ones that span a delay slot. These are an indirect source changing while the slot issues, a stall with the slot pending, a reset that lands with a target pending, and a second branch that arrives inside the slot. The vector table threads a single program path through every kind. It places the register change on the slot cycle, a branch and a call inside slots, and an illegal link-source call on a misaligned address. Directed steps then stall in the middle of a slot and reset in the middle of a slot, and check that the pending target is kept in the first case and discarded in the second.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    BK_NONE     = 3'd0,
    BK_JUMP     = 3'd1,
    BK_JUMP_REG = 3'd2,
    BK_IF_EQ    = 3'd3,
    BK_IF_NE    = 3'd4,
    BK_CALL     = 3'd5,
    BK_CALL_REG = 3'd6
  } br_kind_e;

  function automatic logic kind_is_delayed(br_kind_e k);
    return (k == BK_JUMP) || (k == BK_JUMP_REG) || (k == BK_CALL) || (k == BK_CALL_REG);
  endfunction

  function automatic logic kind_is_cmp(br_kind_e k);
    return (k == BK_IF_EQ) || (k == BK_IF_NE);
  endfunction

  function automatic logic kind_is_call(br_kind_e k);
    return (k == BK_CALL) || (k == BK_CALL_REG);
  endfunction

  function automatic logic kind_is_reg(br_kind_e k);
    return (k == BK_JUMP_REG) || (k == BK_CALL_REG);
  endfunction
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            want_ne_i,
  output logic            hit_o
);
  logic same;
  assign same  = (a_i == b_i);
  assign hit_o = want_ne_i ? !same : same;
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LONG_W  = 26,
  parameter int SHORT_W = 16,
  parameter int SHIFT   = 2
) (
  input  logic [XLEN-1:0]   pc_i,
  input  br_kind_e          kind_i,
  input  logic [LONG_W-1:0] off_i,
  input  logic [XLEN-1:0]   src_val_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   far_tgt_o,
  output logic [XLEN-1:0]   near_tgt_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << SHIFT);

  logic [XLEN-1:0] long_ext, short_ext;

  assign long_ext   = XLEN'($signed(off_i)) << SHIFT;
  assign short_ext  = XLEN'($signed(off_i[SHORT_W-1:0])) << SHIFT;
  assign seq_pc_o   = pc_i + STEP;
  assign near_tgt_o = seq_pc_o + short_ext;
  assign far_tgt_o  = kind_is_reg(kind_i) ? src_val_i : (seq_pc_o + long_ext);
endmodule

// File: rtl/npc_seq.sv
module npc_seq
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              IDX_W    = 5,
  parameter int              LINK_IDX = 1,
  parameter int              SHIFT    = 2,
  parameter logic [XLEN-1:0] RST_PC   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  br_kind_e         kind_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic [XLEN-1:0]  far_tgt_i,
  input  logic [XLEN-1:0]  near_tgt_i,
  input  logic             cmp_hit_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             slot_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_o,
  output logic             err_slot_o,
  output logic             err_link_src_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << SHIFT);

  logic [XLEN-1:0] pc_q, tgt_q, link_q;
  logic            slot_q, lwe_q, eslot_q, esrc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RST_PC;
      tgt_q   <= '0;
      link_q  <= '0;
      slot_q  <= 1'b0;
      lwe_q   <= 1'b0;
      eslot_q <= 1'b0;
      esrc_q  <= 1'b0;
    end else begin
      lwe_q   <= 1'b0;
      eslot_q <= 1'b0;
      esrc_q  <= 1'b0;
      if (issue_i) begin
        if (slot_q) begin
          pc_q    <= tgt_q;
          slot_q  <= 1'b0;
          eslot_q <= (kind_i != BK_NONE);
        end else if (kind_is_delayed(kind_i)) begin
          pc_q   <= seq_pc_i;
          tgt_q  <= far_tgt_i;
          slot_q <= 1'b1;
          if (kind_is_call(kind_i)) begin
            lwe_q  <= 1'b1;
            link_q <= seq_pc_i + STEP;
          end
          esrc_q <= (kind_i == BK_CALL_REG) && (src_idx_i == IDX_W'(LINK_IDX));
        end else if (kind_is_cmp(kind_i) && cmp_hit_i) begin
          pc_q <= near_tgt_i;
        end else begin
          pc_q <= seq_pc_i;
        end
      end
    end
  end

  assign pc_o           = pc_q;
  assign slot_o         = slot_q;
  assign link_we_o      = lwe_q;
  assign link_o         = link_q;
  assign err_slot_o     = eslot_q;
  assign err_link_src_o = esrc_q;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              LONG_W   = 26,
  parameter int              SHORT_W  = 16,
  parameter int              IDX_W    = 5,
  parameter int              LINK_IDX = 1,
  parameter int              SHIFT    = 2,
  parameter logic [XLEN-1:0] RST_PC   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [2:0]        kind_i,
  input  logic [LONG_W-1:0] off_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              slot_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_o,
  output logic              err_slot_o,
  output logic              err_link_src_o
);
  br_kind_e        kind;
  logic [XLEN-1:0] seq_pc, far_tgt, near_tgt;
  logic            cmp_hit;

  assign kind = br_kind_e'(kind_i);

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .a_i       (opa_i),
    .b_i       (opb_i),
    .want_ne_i (kind == BK_IF_NE),
    .hit_o     (cmp_hit)
  );

  npc_target #(
    .XLEN(XLEN), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .SHIFT(SHIFT)
  ) u_tgt (
    .pc_i       (pc_o),
    .kind_i     (kind),
    .off_i      (off_i),
    .src_val_i  (src_val_i),
    .seq_pc_o   (seq_pc),
    .far_tgt_o  (far_tgt),
    .near_tgt_o (near_tgt)
  );

  npc_seq #(
    .XLEN(XLEN), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX), .SHIFT(SHIFT), .RST_PC(RST_PC)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .issue_i        (issue_i),
    .kind_i         (kind),
    .src_idx_i      (src_idx_i),
    .seq_pc_i       (seq_pc),
    .far_tgt_i      (far_tgt),
    .near_tgt_i     (near_tgt),
    .cmp_hit_i      (cmp_hit),
    .pc_o           (pc_o),
    .slot_o         (slot_o),
    .link_we_o      (link_we_o),
    .link_o         (link_o),
    .err_slot_o     (err_slot_o),
    .err_link_src_o (err_link_src_o)
  );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic [2:0]       kind_i,
  input logic [XLEN-1:0]  opa_i,
  input logic [XLEN-1:0]  opb_i,
  input logic [IDX_W-1:0] src_idx_i,
  input logic [XLEN-1:0]  pc_o,
  input logic             slot_o,
  input logic             link_we_o,
  input logic [XLEN-1:0]  link_o,
  input logic             err_slot_o,
  input logic             err_link_src_o
);
  localparam logic [XLEN-1:0] TWO_WORDS = XLEN'(8);

  logic fresh_delayed, fresh_cmp, fresh_call;
  assign fresh_delayed = issue_i && !slot_o &&
                         (kind_i == 3'd1 || kind_i == 3'd2 || kind_i == 3'd5 || kind_i == 3'd6);
  assign fresh_cmp     = issue_i && !slot_o && (kind_i == 3'd3 || kind_i == 3'd4);
  assign fresh_call    = issue_i && !slot_o && (kind_i == 3'd5 || kind_i == 3'd6);

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !slot_o));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> ($stable(pc_o) && $stable(slot_o) && !link_we_o && !err_slot_o));

  assert_slot_follows_R10: assert property (@(posedge clk) disable iff (rst)
    fresh_delayed |=> (slot_o && pc_o == $past(pc_o) + XLEN'(4)));

  assert_slot_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_i && slot_o) |=> !slot_o);

  assert_cmp_no_slot_R6: assert property (@(posedge clk) disable iff (rst)
    fresh_cmp |=> !slot_o);

  assert_cmp_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
    (fresh_cmp && ((kind_i == 3'd3) != (opa_i == opb_i))) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  assert_link_value_R7: assert property (@(posedge clk) disable iff (rst)
    fresh_call |=> (link_we_o && link_o == $past(pc_o) + TWO_WORDS));

  assert_link_src_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (fresh_call && kind_i == 3'd6 && src_idx_i == IDX_W'(LINK_IDX)) |=> err_link_src_o);

  assert_nested_branch_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_i && slot_o && kind_i != 3'd0) |=> (err_slot_o && !link_we_o));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .issue_i        (issue_i),
  .kind_i         (kind_i),
  .opa_i          (opa_i),
  .opb_i          (opb_i),
  .src_idx_i      (src_idx_i),
  .pc_o           (pc_o),
  .slot_o         (slot_o),
  .link_we_o      (link_we_o),
  .link_o         (link_o),
  .err_slot_o     (err_slot_o),
  .err_link_src_o (err_link_src_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  typedef struct packed {
    logic [2:0]  k;
    logic [25:0] off;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] src;
    logic [4:0]  idx;
    logic [31:0] pc;
    logic        slot;
    logic        lwe;
    logic [31:0] link;
    logic        es;
    logic        er;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'h0,     5'd0, 32'h004, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R2
    '{3'd1, 26'h4,       32'd0, 32'd0, 32'h0,     5'd0, 32'h008, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0}, // R3 R10
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'h0,     5'd0, 32'h018, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R3
    '{3'd3, 26'h000FFFE, 32'd5, 32'd5, 32'h0,     5'd0, 32'h014, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R6 eq taken back
    '{3'd4, 26'h8,       32'd5, 32'd5, 32'h0,     5'd0, 32'h018, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R6 ne not taken
    '{3'd3, 26'h4,       32'd1, 32'd2, 32'h0,     5'd0, 32'h01C, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R6 eq not taken
    '{3'd4, 26'h3,       32'd1, 32'd2, 32'h0,     5'd0, 32'h02C, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R6 ne taken
    '{3'd5, 26'h10,      32'd0, 32'd0, 32'h0,     5'd0, 32'h030, 1'b1, 1'b1, 32'h034, 1'b0, 1'b0}, // R7
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'h0,     5'd0, 32'h070, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R3
    '{3'd2, 26'h0,       32'd0, 32'd0, 32'h200,   5'd5, 32'h074, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0}, // R4
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'hDEAD0, 5'd5, 32'h200, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R4 capture
    '{3'd6, 26'h0,       32'd0, 32'd0, 32'h403,   5'd7, 32'h204, 1'b1, 1'b1, 32'h208, 1'b0, 1'b0}, // R7
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'h0,     5'd0, 32'h403, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}, // R5
    '{3'd1, 26'h3FFFFC0, 32'd0, 32'd0, 32'h0,     5'd0, 32'h407, 1'b1, 1'b0, 32'h0,   1'b0, 1'b0}, // R3 negative
    '{3'd3, 26'h20,      32'd9, 32'd9, 32'h0,     5'd0, 32'h307, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0}, // R9
    '{3'd6, 26'h0,       32'd0, 32'd0, 32'h100,   5'd1, 32'h30B, 1'b1, 1'b1, 32'h30F, 1'b0, 1'b1}, // R8
    '{3'd5, 26'h40,      32'd0, 32'd0, 32'h0,     5'd0, 32'h100, 1'b0, 1'b0, 32'h0,   1'b1, 1'b0}, // R9 no link
    '{3'd0, 26'h0,       32'd0, 32'd0, 32'h0,     5'd0, 32'h104, 1'b0, 1'b0, 32'h0,   1'b0, 1'b0}  // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [25:0] off = '0;
  logic [31:0] opa = '0, opb = '0, srcv = '0;
  logic [4:0]  srci = '0;
  logic [31:0] pc, link;
  logic        slot, lwe, es, er;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst(rst), .issue_i(issue), .kind_i(kind), .off_i(off),
    .opa_i(opa), .opb_i(opb), .src_val_i(srcv), .src_idx_i(srci),
    .pc_o(pc), .slot_o(slot), .link_we_o(lwe), .link_o(link),
    .err_slot_o(es), .err_link_src_o(er)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic iss, input logic [2:0] k, input logic [25:0] o,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] s, input logic [4:0] i);
    @(negedge clk);
    issue = iss; kind = k; off = o; opa = a; opb = b; srcv = s; srci = i;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", pc, 32'h0);
    chk("R1 slot", {31'd0, slot}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      step(1'b1, TBL[v].k, TBL[v].off, TBL[v].a, TBL[v].b, TBL[v].src, TBL[v].idx);
      chk($sformatf("R3/R4/R6 pc v%0d", v), pc, TBL[v].pc);
      chk($sformatf("R10 slot v%0d", v), {31'd0, slot}, {31'd0, TBL[v].slot});
      chk($sformatf("R7 link_we v%0d", v), {31'd0, lwe}, {31'd0, TBL[v].lwe});
      if (TBL[v].lwe) chk($sformatf("R7 link v%0d", v), link, TBL[v].link);
      chk($sformatf("R9 err_slot v%0d", v), {31'd0, es}, {31'd0, TBL[v].es});
      chk($sformatf("R5/R8 err_src v%0d", v), {31'd0, er}, {31'd0, TBL[v].er});
    end

    // R2: no issue, a jump on the inputs has no effect
    step(1'b0, 3'd1, 26'h10, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R2 hold pc", pc, 32'h104);
    chk("R2 hold slot", {31'd0, slot}, 32'd0);

    // R10 stall inside a slot keeps the pending target
    step(1'b1, 3'd1, 26'h1, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R10 slot set", {31'd0, slot}, 32'd1);
    chk("R3 slot pc", pc, 32'h108);
    step(1'b0, 3'd0, 26'h0, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R2 stall pc", pc, 32'h108);
    chk("R10 stall slot", {31'd0, slot}, 32'd1);
    step(1'b1, 3'd0, 26'h0, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R3 after stall", pc, 32'h10C);

    // R1: reset with a target pending discards it
    step(1'b1, 3'd1, 26'h100, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R10 slot again", {31'd0, slot}, 32'd1);
    @(negedge clk);
    rst = 1'b1; issue = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 mid-slot pc", pc, 32'h0);
    chk("R1 mid-slot slot", {31'd0, slot}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 3'd0, 26'h0, 32'd0, 32'd0, 32'h0, 5'd0);
    chk("R1 no stale target", pc, 32'h4);
    chk("R1 slot clear", {31'd0, slot}, 32'd0);

    finish_run();
  end
endmodule